// File: doc/BRIEF.md
# Masked Burst Address Counter

This block is the address generator that sits beside one port of a synchronous multi-port memory. It holds an address counter and a companion mask register. A set of active-low control strobes lets the port load the counter, advance it, load the mask, and read either register back. Only the address bits that the mask marks as counting take part in an increment. When the counting bits roll over from all ones, a one-cycle active-low wrap flag tells the port that the burst has come back to its base.

Readback reuses the port's shared address pins, which are modelled as separate input, output and output-enable signals. The requested value appears on the address output one idle cycle after the request and is valid after the second clock edge. If the chip enables select the device while a readback is in flight, a data-disable output goes high together with the address output enable so that the data pins stay tri-stated. The strobes, chip enables and flags are plain level signals, and there is no handshake or back-pressure. A strobe that is held low simply repeats its operation on every edge.

Top module: `bac_burst_counter`

## Requirements
- R1: After reset the counter is zero, the mask is all ones (every bit counts), `wrap_n` is high, and `addr_oe` and `dq_off` are low.
- R2: With `ld_n` low and both readback strobes and `mld_n` high, the counter takes `addr_in` on the clock edge. This applies even when `inc_n` is also low, so load outranks increment.
- R3: With `inc_n` low and `ld_n`, `crb_n`, `mrb_n` and `mld_n` high, the counter advances by one over the bits whose mask bit is 1. The carry skips the bits whose mask bit is 0, and those bits keep their value.
- R4: `wrap_n` goes low for exactly the one cycle after an increment edge at which every unmasked counter bit was 1 and the mask was nonzero. At all other times it is high.
- R5: With `mld_n` low and `ld_n`, `inc_n`, `crb_n` and `mrb_n` high, the mask register takes `addr_in`. Mask bit 0 of `addr_in` maps to counter bit 0.
- R6: With `crb_n` low and `ld_n` and `inc_n` high, a counter readback is requested. Let edge k be the edge that samples the request. `addr_oe` stays low after edge k. After edge k+1, `addr_oe` is high and `addr_out` shows the counter value held at edge k.
- R7: With `mrb_n` low and all four other strobes high, a mask readback is requested. It uses the same two-edge timing as R6 and shows the mask value.
- R8: When `crb_n` and `mrb_n` are both low and `ld_n` and `inc_n` are high, the counter is read back, not the mask.
- R9: Any other strobe combination is a no-operation. The counter and mask keep their values and no readback starts.
- R10: Readback does not depend on the chip enables. `dq_off` is high in the same cycle as a readback's `addr_oe` only if the chip was enabled when the request was sampled, that is `ce0_n` low and `ce1` high. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Counter load strobe, active low |
| inc_n | input | 1 | Counter increment strobe, active low |
| crb_n | input | 1 | Counter readback strobe, active low |
| mld_n | input | 1 | Mask load strobe, active low |
| mrb_n | input | 1 | Mask readback strobe, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| addr_in | input | AW | Address pins as seen by the block |
| addr_out | output | AW | Readback value driven onto the address pins |
| addr_oe | output | 1 | Address pin output enable for readback |
| dq_off | output | 1 | Forces the data pin drivers off during an enabled readback |
| wrap_n | output | 1 | One-cycle active-low counter wrap flag |

## Verification
The increment logic is swept over all sixteen masks of a 4-bit configuration. Each sweep starts from a mask-dependent base and runs past at least one full rollover. This separates carries that skip masked bits from carries that stop at them, and it shows whether the wrap flag follows the unmasked bits or the whole word. All 32 strobe combinations are then applied, each under all four chip-enable pairs, from a fixed counter and mask state. The counter and mask are read back after each one. This separates the legal operations from the conflicting ones, shows the readback priority, and shows whether the data-disable output follows the chip enables. Directed cases cover the reset values, load against increment, and the idle cycle before readback data appears.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_INC   = 3'd2,
    OP_MLOAD = 3'd3,
    OP_CRB   = 3'd4,
    OP_MRB   = 3'd5
  } op_e;
endpackage

// File: rtl/bac_strobe_decode.sv
module bac_strobe_decode
  import bac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_n,
  input  logic inc_n,
  input  logic crb_n,
  input  logic mld_n,
  input  logic mrb_n,
  output op_e  op
);
  logic rb_idle;
  logic cnt_idle;

  assign rb_idle  = crb_n & mrb_n;
  assign cnt_idle = ld_n & inc_n;

  always_comb begin
    if (!ld_n && rb_idle && mld_n)
      op = OP_LOAD;
    else if (!inc_n && rb_idle && mld_n)
      op = OP_INC;
    else if (!mld_n && cnt_idle && rb_idle)
      op = OP_MLOAD;
    else if (!crb_n && cnt_idle)
      op = OP_CRB;
    else if (!mrb_n && cnt_idle && crb_n && mld_n)
      op = OP_MRB;
    else
      op = OP_NOP;
  end

  // R8: counter readback beats mask readback
  a_r8_crb_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!crb_n && !mrb_n && ld_n && inc_n) |-> (op == OP_CRB));

  // R9: a load strobe combined with a readback strobe does nothing
  a_r9_conflict_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !(crb_n && mrb_n)) |-> (op == OP_NOP));
endmodule

// File: rtl/bac_mask_counter.sv
module bac_mask_counter
  import bac_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] cnt,
  output logic [AW-1:0] mask,
  output logic          wrap_n
);
  logic [AW-1:0] filled;
  logic [AW:0]   sum;
  logic [AW-1:0] cnt_inc;
  logic          wraps;

  // masked bits are forced to one so the carry ripples across them
  assign filled  = cnt | ~mask;
  assign sum     = {1'b0, filled} + {{AW{1'b0}}, 1'b1};
  assign cnt_inc = (cnt & ~mask) | (sum[AW-1:0] & mask);
  assign wraps   = sum[AW] & (|mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mask   <= '1;
      wrap_n <= 1'b1;
    end else begin
      wrap_n <= 1'b1;
      case (op)
        OP_LOAD:  cnt <= din;
        OP_MLOAD: mask <= din;
        OP_INC: begin
          cnt    <= cnt_inc;
          wrap_n <= ~wraps;
        end
        default: ;
      endcase
    end
  end

  // R4: flag lasts one cycle
  a_r4_wrap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_n |=> wrap_n);

  // R4: flag only follows an increment
  a_r4_wrap_after_inc: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_n |-> ($past(op) == OP_INC));

  // R3: masked-off bits never move on an increment
  a_r3_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> (((cnt ^ $past(cnt)) & ~$past(mask)) == '0));

  // R9: no-operation and readback leave both registers alone
  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP || op == OP_CRB || op == OP_MRB) |=> ($stable(cnt) && $stable(mask)));
endmodule

// File: rtl/bac_readback_pipe.sv
module bac_readback_pipe
  import bac_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          chip_en,
  input  logic [AW-1:0] cnt,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic          dq_off
);
  logic          s1_vld;
  logic          s1_ce;
  logic [AW-1:0] s1_val;
  logic          req;

  assign req = (op == OP_CRB) || (op == OP_MRB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_ce    <= 1'b0;
      s1_val   <= '0;
      addr_oe  <= 1'b0;
      addr_out <= '0;
      dq_off   <= 1'b0;
    end else begin
      s1_vld   <= req;
      s1_ce    <= chip_en;
      s1_val   <= (op == OP_CRB) ? cnt : mask;
      addr_oe  <= s1_vld;
      addr_out <= s1_vld ? s1_val : '0;
      dq_off   <= s1_vld & s1_ce;
    end
  end

  // R10: data pins are only forced off alongside an address readback
  a_r10_dq_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_off |-> addr_oe);
endmodule

// File: rtl/bac_burst_counter.sv
module bac_burst_counter
  import bac_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          inc_n,
  input  logic          crb_n,
  input  logic          mld_n,
  input  logic          mrb_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic          dq_off,
  output logic          wrap_n
);
  op_e           op;
  logic [AW-1:0] cnt;
  logic [AW-1:0] mask;
  logic          chip_en;

  assign chip_en = ~ce0_n & ce1;

  bac_strobe_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_n  (ld_n),
    .inc_n (inc_n),
    .crb_n (crb_n),
    .mld_n (mld_n),
    .mrb_n (mrb_n),
    .op    (op)
  );

  bac_mask_counter #(.AW(AW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .din    (addr_in),
    .cnt    (cnt),
    .mask   (mask),
    .wrap_n (wrap_n)
  );

  bac_readback_pipe #(.AW(AW)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .chip_en  (chip_en),
    .cnt      (cnt),
    .mask     (mask),
    .addr_out (addr_out),
    .addr_oe  (addr_oe),
    .dq_off   (dq_off)
  );

  // R6: the output enable only follows a request two edges earlier
  a_r6_oe_source: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> $past(op == OP_CRB || op == OP_MRB, 2));

  // R6: counter readback shows the value at request time
  a_r6_cnt_value: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && $past(op == OP_CRB, 2)) |-> (addr_out == $past(cnt, 2)));

  // R7: mask readback shows the mask at request time
  a_r7_mask_value: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && $past(op == OP_MRB, 2)) |-> (addr_out == $past(mask, 2)));
endmodule

// File: tb/sim_bac_burst_counter.sv
`timescale 1ns/1ps
module sim_bac_burst_counter;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, inc_n = 1'b1, crb_n = 1'b1, mld_n = 1'b1, mrb_n = 1'b1;
  logic ce0_n = 1'b1, ce1 = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic addr_oe, dq_off, wrap_n;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bac_burst_counter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .inc_n(inc_n), .crb_n(crb_n),
    .mld_n(mld_n), .mrb_n(mrb_n), .ce0_n(ce0_n), .ce1(ce1),
    .addr_in(addr_in), .addr_out(addr_out), .addr_oe(addr_oe),
    .dq_off(dq_off), .wrap_n(wrap_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ld_n = 1'b1; inc_n = 1'b1; crb_n = 1'b1; mld_n = 1'b1; mrb_n = 1'b1;
  endtask

  task automatic do_load(input int v);
    idle(); ld_n = 1'b0; addr_in = AW'(v); tick(); idle();
  endtask

  task automatic do_mload(input int v);
    idle(); mld_n = 1'b0; addr_in = AW'(v); tick(); idle();
  endtask

  // issue a readback, check the idle gap, return the value seen after edge k+1
  task automatic rd(input bit of_mask, input string tag, output int val);
    idle();
    if (of_mask) mrb_n = 1'b0; else crb_n = 1'b0;
    tick();
    idle();
    chk({tag, " gap oe"}, int'(addr_oe), 0);
    tick();
    chk({tag, " oe"}, int'(addr_oe), 1);
    val = int'(addr_out);
  endtask

  // reference increment: gather unmasked bits, add one, scatter back
  function automatic int ref_inc(input int c, input int m, output bit wr);
    int k = 0;
    int j = 0;
    int r;
    int k2;
    for (int b = 0; b < AW; b++)
      if (m[b]) begin k |= ((c >> b) & 1) << j; j++; end
    wr = (j > 0) && (k == (1 << j) - 1);
    k2 = (k + 1) & ((1 << j) - 1);
    r = c & ~m & ((1 << AW) - 1);
    j = 0;
    for (int b = 0; b < AW; b++)
      if (m[b]) begin r |= ((k2 >> j) & 1) << b; j++; end
    return r;
  endfunction

  // reference decode: 0 nop, 1 load, 2 inc, 3 mask load, 4 cnt rb, 5 mask rb
  function automatic int ref_op(input bit l, input bit i, input bit cr, input bit ml, input bit mr);
    if (!l && cr && mr && ml) return 1;
    if (!i && cr && mr && ml) return 2;
    if (!ml && l && i && cr && mr) return 3;
    if (!cr && l && i) return 4;
    if (!mr && l && i && cr && ml) return 5;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    int c;
    int nx;
    bit wr;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset values
    chk("R1 wrap_n", int'(wrap_n), 1);
    chk("R1 addr_oe", int'(addr_oe), 0);
    chk("R1 dq_off", int'(dq_off), 0);
    rd(1'b0, "R1 cnt", v); chk("R1 cnt value", v, 0);
    rd(1'b1, "R1 mask", v); chk("R1 mask value", v, (1 << AW) - 1);

    // R3/R4/R5 sweep over every mask
    for (int m = 0; m < (1 << AW); m++) begin
      do_mload(m);
      rd(1'b1, "R5 mask", v); chk("R5 mask value", v, m);
      c = (m * 5 + 3) & ((1 << AW) - 1);
      do_load(c);
      rd(1'b0, "R2 cnt", v); chk("R2 load value", v, c);
      for (int s = 0; s < 18; s++) begin
        nx = ref_inc(c, m, wr);
        idle(); inc_n = 1'b0; tick(); idle();
        chk("R4 wrap_n", int'(wrap_n), wr ? 0 : 1);
        tick();
        chk("R4 wrap_n release", int'(wrap_n), 1);
        rd(1'b0, "R3 cnt", v); chk("R3 inc value", v, nx);
        c = nx;
      end
    end

    // R2 load outranks increment
    do_mload((1 << AW) - 1);
    do_load(5);
    idle(); ld_n = 1'b0; inc_n = 1'b0; addr_in = AW'(9); tick(); idle();
    rd(1'b0, "R2 prio", v); chk("R2 load over inc", v, 9);

    // R8 both readback strobes: counter wins
    do_mload(3); do_load(6);
    idle(); crb_n = 1'b0; mrb_n = 1'b0; tick(); idle();
    chk("R8 gap oe", int'(addr_oe), 0);
    tick();
    chk("R8 oe", int'(addr_oe), 1);
    chk("R8 counter shown", int'(addr_out), 6);
    tick();
    chk("R6 oe drops", int'(addr_oe), 0);

    // R9/R10 every strobe combination under every chip-enable pair
    for (int i = 0; i < 128; i++) begin
      int op;
      int ec;
      int em;
      bit en;
      ce0_n = 1'b1; ce1 = 1'b0;
      do_mload(11); do_load(6);
      op = ref_op(i[0], i[1], i[2], i[3], i[4]);
      ce0_n = i[5]; ce1 = i[6];
      en = !i[5] && i[6];
      ld_n = i[0]; inc_n = i[1]; crb_n = i[2]; mld_n = i[3]; mrb_n = i[4];
      addr_in = AW'(9);
      tick();
      idle();
      tick();
      ec = 6; em = 11;
      case (op)
        1: ec = 9;
        2: ec = 7;
        3: em = 9;
        default: ;
      endcase
      if (op == 4 || op == 5) begin
        chk("R10 readback oe", int'(addr_oe), 1);
        chk(op == 4 ? "R6 combo value" : "R7 combo value", int'(addr_out), op == 4 ? 6 : 11);
        chk("R10 dq_off", int'(dq_off), en ? 1 : 0);
      end else begin
        chk("R9 no readback oe", int'(addr_oe), 0);
        chk("R10 dq_off idle", int'(dq_off), 0);
      end
      ce0_n = 1'b1; ce1 = 1'b0;
      rd(1'b0, "R9 cnt", v); chk("R9 cnt after combo", v, ec);
      rd(1'b1, "R9 mask", v); chk("R9 mask after combo", v, em);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule